// File: doc/BRIEF.md
# Disk Controller Host Register Interface

This block is the CPU-facing front end of a microcoded disk controller. The CPU sees two byte locations on its bus. The lower address is a command/data register that can be read and written. The next address up is a status register that can only be read, and a write to it resets the controller. Two flags coordinate the byte traffic. One tells the CPU that a byte it wrote has not yet been taken by the controller. The other tells it that a byte is waiting to be read. A busy bit marks the time during which a command is in progress.

The CPU writes a command byte, and the block decodes it. If the command needs parameter bytes, the block collects them one at a time. It then presents the decoded operation to the controller engine, with the parameters packed most significant byte first, and pulses a start strobe. When the engine reports done, its result byte is loaded into the register for the CPU to read. A command byte outside the defined set is answered directly with an error code, and the engine is not involved. RAM access, DMA movement, drive registers and command-string execution are left to the engine behind a start/done port.

Top module: `dkc_host_if`

## Requirements
- R1: A read at BASE_ADDR+1 returns the status byte {4'b0, busy, 1'b0, in_pending, out_ready}: bit 0 is out_ready, bit 1 is in_pending, bit 2 is always 0, bit 3 is busy, and bits 7..4 are 0. After reset every bit is 0, and a read of BASE_ADDR returns 00h.
- R2: A write to BASE_ADDR+1 with any data clears in_pending, out_ready, busy and any partly collected command on the next edge. The same write raises ctl_rst_o for exactly one cycle.
- R3: A CPU write to BASE_ADDR sets in_pending on that edge. The block consumes the byte and clears in_pending on the next edge. A data write made while in_pending or busy is set is ignored.
- R4: When a result is loaded, out_ready is set. A CPU read of BASE_ADDR returns the result byte and clears out_ready.
- R5: The number of parameter bytes is fixed by the opcode: 41h takes 2, 46h and 47h take 4, 60h–6Fh take 1, and every other valid opcode takes none. Parameters are shifted into eng_arg_o, first byte most significant and right-justified. For example, 46h 12 34 00 80 gives 12340080h. eng_cmd_o carries the command byte.
- R6: eng_op_o encodes the operation: 1xh=0 (RAM byte read), 41h=1 (CRC seed), 43h=2 (buffer load), 45h=3 (buffer execute), 46h=4 (DMA to device), 47h=5 (DMA to host), 50h–5Fh=6 (register read), 60h=7 (control register 1 load), 61h–6Fh=8 (control register 2 load).
- R7: eng_start_o pulses for one cycle on the edge after the final byte of a valid command is consumed. Busy is high from that cycle until the edge on which eng_done_i is sampled. On that edge busy drops and eng_result_i is loaded with out_ready set.
- R8: Any opcode outside the set in R6 loads error 12h with out_ready set. It produces no start pulse, and busy stays 0.
- R9: Opcodes 56h–5Fh are accepted as register reads (op 6) and do not return 12h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus cycle valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| eng_start_o | output | 1 | One-cycle operation start |
| eng_op_o | output | 4 | Decoded operation code |
| eng_cmd_o | output | 8 | Raw command byte |
| eng_arg_o | output | 8*MAX_PARAMS | Collected parameters, first byte most significant |
| eng_done_i | input | 1 | Engine finished, result valid |
| eng_result_i | input | 8 | Engine result or error byte |
| ctl_rst_o | output | 1 | One-cycle controller reset pulse |

## Verification
The bench targets four kinds of error.

- **Premature start.** Parameter counts are checked across each opcode family. An off-by-one count would start the engine early, or would swallow the next command as a parameter.
- **Overwritten byte.** Writes are fired back to back, and also while the block is busy. A design that ignored in_pending or busy would replace a byte that had not yet been consumed, or would start a phantom command.
- **Errors at range edges.** Invalid opcodes sit next to valid ranges (20h, 42h, 44h, 48h, 70h). A loose range decode would send them to the engine instead of answering with 12h, and the 56h–5Fh window is checked for the opposite mistake.
- **Leftover state after reset.** Resets are issued in the middle of parameter collection and while a result is pending. A design that kept partial state would treat the next command byte as a stale parameter.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_RAM_RD      = 4'd0,
    OP_CRC_SEED    = 4'd1,
    OP_BUF_LOAD    = 4'd2,
    OP_BUF_EXEC    = 4'd3,
    OP_DMA_TO_DEV  = 4'd4,
    OP_DMA_TO_HOST = 4'd5,
    OP_REG_RD      = 4'd6,
    OP_CR1_LD      = 4'd7,
    OP_CR2_LD      = 4'd8
  } op_e;

  typedef struct packed {
    logic       valid;
    op_e        op;
    logic [2:0] nparam;
  } cmd_info_t;
endpackage

// File: rtl/dkc_cmd_decode.sv
module dkc_cmd_decode
  import dkc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  output cmd_info_t         info_o
);
  always_comb begin
    info_o = '{valid: 1'b0, op: OP_RAM_RD, nparam: 3'd0};
    unique case (cmd_i[7:4])
      4'h1: info_o = '{valid: 1'b1, op: OP_RAM_RD, nparam: 3'd0};
      4'h4: begin
        case (cmd_i[3:0])
          4'h1: info_o = '{valid: 1'b1, op: OP_CRC_SEED,    nparam: 3'd2};
          4'h3: info_o = '{valid: 1'b1, op: OP_BUF_LOAD,    nparam: 3'd0};
          4'h5: info_o = '{valid: 1'b1, op: OP_BUF_EXEC,    nparam: 3'd0};
          4'h6: info_o = '{valid: 1'b1, op: OP_DMA_TO_DEV,  nparam: 3'd4};
          4'h7: info_o = '{valid: 1'b1, op: OP_DMA_TO_HOST, nparam: 3'd4};
          default: ;
        endcase
      end
      // 56h-5Fh deliberately share the register-read path
      4'h5: info_o = '{valid: 1'b1, op: OP_REG_RD, nparam: 3'd0};
      4'h6: begin
        if (cmd_i[3:0] == 4'h0) info_o = '{valid: 1'b1, op: OP_CR1_LD, nparam: 3'd1};
        else                    info_o = '{valid: 1'b1, op: OP_CR2_LD, nparam: 3'd1};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dkc_hs_flags.sv
module dkc_hs_flags
  import dkc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              consume_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              rd_i,
  output logic              fin_o,
  output logic              fout_o,
  output logic [BYTE_W-1:0] in_byte_o,
  output logic [BYTE_W-1:0] out_byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_o      <= 1'b0;
      fout_o     <= 1'b0;
      in_byte_o  <= '0;
      out_byte_o <= '0;
    end else if (clr_i) begin
      fin_o  <= 1'b0;
      fout_o <= 1'b0;
    end else begin
      if (wr_i) begin
        fin_o     <= 1'b1;
        in_byte_o <= wdata_i;
      end else if (consume_i) begin
        fin_o <= 1'b0;
      end
      // a fresh result wins over a simultaneous CPU read
      if (load_i) begin
        fout_o     <= 1'b1;
        out_byte_o <= load_data_i;
      end else if (rd_i) begin
        fout_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dkc_seq.sv
module dkc_seq
  import dkc_pkg::*;
#(
  parameter int               MAX_PARAMS  = 4,
  parameter logic [BYTE_W-1:0] ERR_BAD_CMD = 8'h12,
  localparam int              ARG_W       = BYTE_W * MAX_PARAMS,
  localparam int              CNT_W       = $clog2(MAX_PARAMS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fin_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  cmd_info_t         info_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] result_i,
  output logic              consume_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_data_o,
  output logic              busy_o,
  output logic              start_o,
  output op_e               op_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [ARG_W-1:0]  arg_o
);
  typedef enum logic [1:0] {S_IDLE, S_PARAM, S_START, S_WAIT} state_e;

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      op_o    <= OP_RAM_RD;
      cmd_o   <= '0;
      arg_o   <= '0;
    end else if (clr_i) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (fin_i) begin
          cmd_o <= in_byte_i;
          op_o  <= info_i.op;
          arg_o <= '0;
          cnt_q <= CNT_W'(info_i.nparam);
          if (info_i.valid)
            state_q <= (info_i.nparam == 3'd0) ? S_START : S_PARAM;
        end
        S_PARAM: if (fin_i) begin
          arg_o <= {arg_o[ARG_W-BYTE_W-1:0], in_byte_i};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= S_START;
        end
        S_START: state_q <= S_WAIT;
        S_WAIT:  if (done_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    consume_o   = fin_i && (state_q == S_IDLE || state_q == S_PARAM);
    start_o     = (state_q == S_START);
    busy_o      = (state_q == S_START) || (state_q == S_WAIT);
    load_o      = 1'b0;
    load_data_o = result_i;
    if (state_q == S_IDLE && fin_i && !info_i.valid) begin
      load_o      = 1'b1;
      load_data_o = ERR_BAD_CMD;
    end else if (state_q == S_WAIT && done_i) begin
      load_o = 1'b1;
    end
  end
endmodule

// File: rtl/dkc_host_if.sv
module dkc_host_if
  import dkc_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'hF800,
  parameter int                MAX_PARAMS  = 4,
  parameter logic [7:0]        ERR_BAD_CMD = 8'h12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_sel_i,
  input  logic                      bus_we_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [7:0]                bus_wdata_i,
  output logic [7:0]                bus_rdata_o,
  output logic                      eng_start_o,
  output logic [3:0]                eng_op_o,
  output logic [7:0]                eng_cmd_o,
  output logic [8*MAX_PARAMS-1:0]   eng_arg_o,
  input  logic                      eng_done_i,
  input  logic [7:0]                eng_result_i,
  output logic                      ctl_rst_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);

  logic hit_data, hit_stat, wr_data, wr_stat, rd_data, wr_acc;
  logic fin, fout, busy, consume, load;
  logic [7:0] in_byte, out_byte, load_data;
  cmd_info_t info;
  op_e op;

  assign hit_data = bus_sel_i && (bus_addr_i == BASE_ADDR);
  assign hit_stat = bus_sel_i && (bus_addr_i == STAT_ADDR);
  assign wr_data  = hit_data && bus_we_i;
  assign wr_stat  = hit_stat && bus_we_i;
  assign rd_data  = hit_data && !bus_we_i;
  assign wr_acc   = wr_data && !fin && !busy;

  always_comb begin
    bus_rdata_o = '0;
    if (hit_data && !bus_we_i)      bus_rdata_o = out_byte;
    else if (hit_stat && !bus_we_i) bus_rdata_o = {4'b0000, busy, 1'b0, fin, fout};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_rst_o <= 1'b0;
    else         ctl_rst_o <= wr_stat;
  end

  dkc_hs_flags u_flags (
    .clk_i, .rst_ni,
    .clr_i       (wr_stat),
    .wr_i        (wr_acc),
    .wdata_i     (bus_wdata_i),
    .consume_i   (consume),
    .load_i      (load),
    .load_data_i (load_data),
    .rd_i        (rd_data),
    .fin_o       (fin),
    .fout_o      (fout),
    .in_byte_o   (in_byte),
    .out_byte_o  (out_byte)
  );

  dkc_cmd_decode u_dec (
    .cmd_i  (in_byte),
    .info_o (info)
  );

  dkc_seq #(
    .MAX_PARAMS  (MAX_PARAMS),
    .ERR_BAD_CMD (ERR_BAD_CMD)
  ) u_seq (
    .clk_i, .rst_ni,
    .clr_i       (wr_stat),
    .fin_i       (fin),
    .in_byte_i   (in_byte),
    .info_i      (info),
    .done_i      (eng_done_i),
    .result_i    (eng_result_i),
    .consume_o   (consume),
    .load_o      (load),
    .load_data_o (load_data),
    .busy_o      (busy),
    .start_o     (eng_start_o),
    .op_o        (op),
    .cmd_o       (eng_cmd_o),
    .arg_o       (eng_arg_o)
  );

  assign eng_op_o = op;
endmodule

// File: rtl/dkc_host_if_chk.sv
module dkc_host_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_stat_i,
  input logic rd_data_i,
  input logic fin_i,
  input logic fout_i,
  input logic busy_i,
  input logic start_i,
  input logic done_i,
  input logic ctl_rst_i
);
  a_r2_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i |=> (!fin_i && !fout_i && !busy_i && ctl_rst_i));

  a_r3_fin_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> !fin_i);

  a_r4_fout_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !fin_i && !busy_i && !wr_stat_i) |=> !fout_i);

  a_r7_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wr_stat_i) |=> (!start_i && busy_i));

  a_r7_done_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !start_i && done_i && !wr_stat_i) |=> (fout_i && !busy_i));
endmodule

bind dkc_host_if dkc_host_if_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_stat_i (wr_stat),
  .rd_data_i (rd_data),
  .fin_i     (fin),
  .fout_i    (fout),
  .busy_i    (busy),
  .start_i   (eng_start_o),
  .done_i    (eng_done_i),
  .ctl_rst_i (ctl_rst_o)
);

// File: tb/dkc_host_if_test.sv
`timescale 1ns/1ps
module dkc_host_if_test;
  localparam logic [15:0] BASE = 16'hF800;
  localparam int ENG_LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic eng_start, eng_done = 1'b0, ctl_rst;
  logic [3:0] eng_op;
  logic [7:0] eng_cmd, eng_result = '0;
  logic [31:0] eng_arg;

  int checks = 0, failures = 0, start_cnt = 0, rst_pulses = 0;
  logic [43:0] exp_start_q[$];
  logic [7:0]  exp_res_q[$];

  always #10 clk = ~clk;

  dkc_host_if uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .eng_start_o(eng_start), .eng_op_o(eng_op), .eng_cmd_o(eng_cmd),
    .eng_arg_o(eng_arg), .eng_done_i(eng_done), .eng_result_i(eng_result),
    .ctl_rst_o(ctl_rst)
  );

  function automatic logic [7:0] eng_fn(input logic [7:0] c, input logic [31:0] a);
    return c ^ a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hC3;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine model: scoreboard on start, delayed done with result
  initial begin
    forever begin
      @(negedge clk);
      if (ctl_rst) rst_pulses++;
      if (eng_start) begin
        logic [43:0] got, exp;
        start_cnt++;
        got = {eng_op, eng_cmd, eng_arg};
        if (exp_start_q.size() == 0) begin
          check(1'b0, "R5/R6 unexpected start", got, 0);
        end else begin
          exp = exp_start_q.pop_front();
          check(got == exp, "R5/R6 start op/cmd/arg", got, exp);
        end
        repeat (ENG_LAT) @(negedge clk);
        eng_result = eng_fn(got[39:32], got[31:0]);
        eng_done = 1'b1;
        @(negedge clk);
        if (ctl_rst) rst_pulses++;
        eng_done = 1'b0;
      end
    end
  end

  task automatic bus_wr(input bit stat, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = BASE + 16'(stat); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // starts at current negedge, ends at the next one
  task automatic bus_rd(input bit stat, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = BASE + 16'(stat);
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [7:0] s;
    int n = 0;
    @(negedge clk);
    bus_rd(1'b1, s);
    while (s[1] || s[3]) begin
      n++;
      if (n > 200) begin check(1'b0, "R3 in_pending never clears", s, 0); break; end
      bus_rd(1'b1, s);
    end
    bus_wr(1'b0, b);
  endtask

  task automatic get_result(input string req);
    logic [7:0] s, d, e;
    int n = 0;
    @(negedge clk);
    bus_rd(1'b1, s);
    while (!s[0]) begin
      n++;
      if (n > 200) begin check(1'b0, {req, " no result"}, s, 1); return; end
      bus_rd(1'b1, s);
    end
    check(s[3] == 1'b0, {req, " R7 busy low with result"}, s[3], 0);
    bus_rd(1'b0, d);
    e = (exp_res_q.size() != 0) ? exp_res_q.pop_front() : 8'hxx;
    check(d == e, {req, " R4 result byte"}, d, e);
    bus_rd(1'b1, s);
    check(s[0] == 1'b0, {req, " R4 out_ready cleared by read"}, s, 0);
  endtask

  task automatic issue(input logic [7:0] cmd, input int n, input logic [31:0] prm,
                       input logic [3:0] op, input string req);
    exp_start_q.push_back({op, cmd, prm});
    exp_res_q.push_back(eng_fn(cmd, prm));
    send_byte(cmd);
    for (int i = n - 1; i >= 0; i--) send_byte(prm[8*i +: 8]);
    get_result(req);
  endtask

  task automatic issue_bad(input logic [7:0] cmd);
    int sc = start_cnt;
    exp_res_q.push_back(8'h12);
    send_byte(cmd);
    get_result("R8 invalid opcode");
    repeat (ENG_LAT + 2) @(negedge clk);
    check(start_cnt == sc, "R8 no start for invalid opcode", start_cnt, sc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_rd(1'b1, s);
    check(s == 8'h00, "R1 status after reset", s, 0);
    bus_rd(1'b0, d);
    check(d == 8'h00, "R1 data after reset", d, 0);
    check(ctl_rst == 1'b0, "R2 no reset pulse at start", ctl_rst, 0);

    // R3 in_pending set one cycle then consumed
    bus_wr(1'b0, 8'h60);
    bus_rd(1'b1, s);
    check(s == 8'h02, "R3 in_pending set after write", s, 8'h02);
    bus_rd(1'b1, s);
    check(s == 8'h00, "R3 in_pending cleared after consume", s, 0);
    exp_start_q.push_back({4'd7, 8'h60, 32'h5A});
    exp_res_q.push_back(eng_fn(8'h60, 32'h5A));
    send_byte(8'h5A);
    get_result("R5 R6 control reg 1 load");

    // R6 op map, R5 param counts
    issue(8'h13, 0, 32'h0, 4'd0, "R6 RAM read");
    issue(8'h1F, 0, 32'h0, 4'd0, "R6 RAM read top");
    issue(8'h52, 0, 32'h0, 4'd6, "R6 register read");
    issue(8'h41, 2, 32'h0000ABCD, 4'd1, "R5 CRC seed");
    issue(8'h43, 0, 32'h0, 4'd2, "R6 buffer load");
    issue(8'h45, 0, 32'h0, 4'd3, "R6 buffer execute");
    issue(8'h46, 4, 32'h12340080, 4'd4, "R5 DMA to device");
    issue(8'h47, 4, 32'h0FFF0001, 4'd5, "R5 DMA to host");
    issue(8'h6C, 1, 32'h33, 4'd8, "R5 control reg 2 load");
    issue(8'h61, 1, 32'h81, 4'd8, "R6 control reg 2 low edge");
    issue(8'h56, 0, 32'h0, 4'd6, "R9 opcode 56h accepted");
    issue(8'h5F, 0, 32'h0, 4'd6, "R9 opcode 5Fh accepted");

    // R8 invalid opcodes around valid ranges
    issue_bad(8'h00);
    issue_bad(8'h20);
    issue_bad(8'h42);
    issue_bad(8'h44);
    issue_bad(8'h48);
    issue_bad(8'h70);
    issue_bad(8'hFF);

    // R3 back-to-back write ignored while in_pending
    exp_start_q.push_back({4'd7, 8'h60, 32'hA5});
    exp_res_q.push_back(eng_fn(8'h60, 32'hA5));
    bus_wr(1'b0, 8'h60);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = BASE; bus_wdata = 8'h77;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    send_byte(8'hA5);
    get_result("R3 write while in_pending ignored");

    // R7 busy visible, R3 write during busy ignored
    sc = start_cnt;
    exp_start_q.push_back({4'd3, 8'h45, 32'h0});
    exp_res_q.push_back(eng_fn(8'h45, 32'h0));
    send_byte(8'h45);
    @(negedge clk);
    bus_rd(1'b1, s);
    check(s == 8'h08, "R7 busy during engine run", s, 8'h08);
    bus_wr(1'b0, 8'h13);
    bus_rd(1'b1, s);
    check(s[1] == 1'b0, "R3 write during busy ignored", s, 0);
    get_result("R7 engine result");
    repeat (ENG_LAT + 4) @(negedge clk);
    check(start_cnt == sc + 1, "R3 R7 exactly one start", start_cnt, sc + 1);

    // R2 reset mid-command
    sc = start_cnt;
    send_byte(8'h46);
    send_byte(8'h11);
    send_byte(8'h22);
    @(negedge clk);
    bus_rd(1'b1, s);
    bus_wr(1'b1, 8'hFF);
    bus_rd(1'b1, s);
    check(s == 8'h00, "R2 status clear after reset write", s, 0);
    check(rst_pulses == 1, "R2 one ctl reset pulse", rst_pulses, 1);
    issue(8'h52, 0, 32'h0, 4'd6, "R2 fresh command after reset");
    check(start_cnt == sc + 1, "R2 aborted command never started", start_cnt, sc + 1);

    // R2 reset drops pending result
    send_byte(8'h70);
    repeat (3) @(negedge clk);
    bus_rd(1'b1, s);
    check(s == 8'h01, "R8 error pending", s, 8'h01);
    bus_wr(1'b1, 8'h00);
    bus_rd(1'b1, s);
    check(s == 8'h00, "R2 reset clears out_ready", s, 0);
    check(rst_pulses == 2, "R2 second reset pulse", rst_pulses, 2);

    repeat (4) @(negedge clk);
    check(exp_start_q.size() == 0, "R5 all expected starts seen", exp_start_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule